// File: doc/BRIEF.md
# FSM State Upset Detector with Recovery Jump

This block guards the state register of a finite state machine against single event upsets. The machine's own next-state logic lives outside: it presents the next state on every clock, and the block stores it and hands back a checked copy of the present state. The FSM must compute its next state from that checked copy, never from a raw register.

Two encoding variants are chosen by a parameter. In parity mode, two extra flops hold the odd parity and the even parity of every stored next state. The present state is declared upset only when both recomputed parities disagree with both stored ones. In one-hot or one-cold mode no extra flops are kept, and any code without exactly one active bit is declared upset. On an upset the checked state is replaced by a recovery state fixed by parameter; nothing is repaired. The FSM then runs on from the recovery state.

A fault-injection mask input XORs flips into the flops as they load, so the detection path can be exercised through the normal ports.

Top module: `guard_fsm_upset`

## Requirements
- R1: While rst_n is low at a rising edge, the state flop loads RESET_STATE and the parity flops load matching parity, with flip_mask ignored. After reset, upset is 0 and corrected_state equals RESET_STATE.
- R2: With no flip injected and a stored code that passes the check, corrected_state equals the next_state sampled at the previous rising edge, and upset is 0.
- R3: In parity mode, the parity flop p0 stores the odd parity of next_state (XNOR of its bits) and p1 stores the even parity (XOR of its bits). Any next_state code, legal for the FSM or not, therefore passes through with upset 0 when no flip is injected.
- R4: flip_mask bits [STATE_W-1:0] invert the corresponding state bits as they load. In parity mode, one such flip makes upset 1 and corrected_state equal RECOVERY_STATE in the following cycle.
- R5: flip_mask bit STATE_W inverts p0 and bit STATE_W+1 inverts p1. In parity mode, flipping exactly one of them leaves upset 0 and corrected_state equal to the true stored state.
- R6: In parity mode, flipping both parity flops with a clean state gives upset 1 and corrected_state equal to RECOVERY_STATE.
- R7: Once a recovery has been taken and the FSM feeds back a clean next state, upset returns to 0 one cycle later.
- R8: In one-hot mode, a stored code whose count of ones is not exactly one (for example 0101 or 0000) gives upset 1 and corrected_state equal to RECOVERY_STATE (1000 for the four-state example). The parity flip bits have no effect.
- R9: In one-cold mode, a stored code whose count of zeros is not exactly one gives upset 1 and corrected_state equal to RECOVERY_STATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| next_state | input | STATE_W | Next state from the FSM transition logic |
| flip_mask | input | STATE_W+2 | Fault injection: state bit flips, then p0, then p1 |
| corrected_state | output | STATE_W | Checked present state, or the recovery state on an upset |
| upset | output | 1 | High while the stored state fails its check |

## Verification
Both outputs are combinational views of flops loaded at a rising edge. For a next_state and flip_mask presented before an edge, corrected_state and upset are therefore due right after that edge, and the recovery jump shows in that same cycle. Clearing after a recovery is due one edge later, once the FSM has fed the recovery state back. The bench drives on the falling edge, updates its own model of the stored flops at the same time, and compares both outputs on the next falling edge. This covers every instance: parity, one-hot and one-cold.

// File: rtl/guard_pkg.sv
// Shared types and helper functions for the FSM state upset detector.
// Assumes state codes are plain packed vectors of any width.
package guard_pkg;

    typedef enum logic [1:0] {
        ENC_PARITY   = 2'd0,
        ENC_ONE_HOT  = 2'd1,
        ENC_ONE_COLD = 2'd2
    } enc_mode_e;

    // Odd parity bit: value that makes the total count of ones odd.
    function automatic logic odd_par(input logic [63:0] v, input int unsigned w);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < 64; i++)
            if (i < w) acc = acc ^ v[i];
        return acc;
    endfunction

    // Even parity bit: value that makes the total count of ones even.
    function automatic logic even_par(input logic [63:0] v, input int unsigned w);
        return ~odd_par(v, w);
    endfunction

    // True when exactly one of the low w bits is set (XOR/AND chain).
    function automatic logic exactly_one(input logic [63:0] v, input int unsigned w);
        logic seen;
        logic dup;
        seen = 1'b0;
        dup  = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) begin
                dup  = dup | (seen & v[i]);
                seen = seen ^ v[i];
            end
        end
        return seen & ~dup;
    endfunction

endpackage

// File: rtl/guard_store.sv
// State flops plus, in parity mode, the two parity flops.
// Assumes a synchronous active-low reset. The injection mask is XORed
// into the loaded values and is ignored during reset.
module guard_store
    import guard_pkg::*;
#(
    parameter int unsigned           STATE_W     = 4,
    parameter enc_mode_e             MODE        = ENC_PARITY,
    parameter logic [STATE_W-1:0]    RESET_STATE = 4'b0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] next_state,
    input  logic [STATE_W+1:0] flip_mask,
    output logic [STATE_W-1:0] state_q,
    output logic [1:0]         par_q
);
    localparam logic [63:0] RESET_WIDE = 64'(RESET_STATE);

    logic [63:0] next_wide;
    assign next_wide = 64'(next_state);

    // Load the next state, applying any injected state-bit flips.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= next_state ^ flip_mask[STATE_W-1:0];
    end

    generate
        if (MODE == ENC_PARITY) begin : g_par
            // Store p0 (odd) in bit 0 and p1 (even) in bit 1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    par_q <= {even_par(RESET_WIDE, STATE_W), odd_par(RESET_WIDE, STATE_W)};
                else
                    par_q <= {even_par(next_wide, STATE_W), odd_par(next_wide, STATE_W)}
                             ^ flip_mask[STATE_W+1:STATE_W];
            end
        end else begin : g_nopar
            logic unused_par_flip;
            logic unused_next_wide;
            // Without parity flops the upper mask bits have no load path.
            assign unused_par_flip  = ^flip_mask[STATE_W+1:STATE_W];
            assign unused_next_wide = ^next_wide;
            assign par_q = 2'b00;
        end
    endgenerate

endmodule

// File: rtl/guard_detect.sv
// Upset detector: in parity mode, compares recomputed parities with the
// stored ones and flags only a double mismatch. In one-hot or one-cold
// mode, flags any code without exactly one active bit.
module guard_detect
    import guard_pkg::*;
#(
    parameter int unsigned STATE_W = 4,
    parameter enc_mode_e   MODE    = ENC_PARITY
) (
    input  logic [STATE_W-1:0] state_q,
    input  logic [1:0]         par_q,
    output logic               upset_raw
);
    logic [63:0] q_wide;
    assign q_wide = 64'(state_q);

    generate
        if (MODE == ENC_PARITY) begin : g_par
            logic p0_calc, p1_calc;
            // Recompute both parities from the present state.
            always_comb begin
                p0_calc   = odd_par(q_wide, STATE_W);
                p1_calc   = even_par(q_wide, STATE_W);
                upset_raw = (par_q[0] != p0_calc) && (par_q[1] != p1_calc);
            end
        end else if (MODE == ENC_ONE_HOT) begin : g_hot
            logic unused_par;
            assign unused_par = ^par_q;
            // A legal one-hot code has exactly one bit set.
            always_comb upset_raw = ~exactly_one(q_wide, STATE_W);
        end else begin : g_cold
            logic unused_par;
            assign unused_par = ^par_q;
            // A legal one-cold code has exactly one bit clear.
            always_comb upset_raw = ~exactly_one(~q_wide, STATE_W);
        end
    endgenerate

endmodule

// File: rtl/guard_recover.sv
// Output selector: passes the present state through, or substitutes the
// recovery state when the detector has flagged an upset.
module guard_recover #(
    parameter int unsigned        STATE_W        = 4,
    parameter logic [STATE_W-1:0] RECOVERY_STATE = 4'b1000
) (
    input  logic [STATE_W-1:0] state_q,
    input  logic               upset_raw,
    output logic [STATE_W-1:0] corrected_state,
    output logic               upset
);
    // Jump to the recovery code on an upset; no repair is attempted.
    always_comb begin
        corrected_state = upset_raw ? RECOVERY_STATE : state_q;
        upset           = upset_raw;
    end
endmodule

// File: rtl/guard_fsm_upset.sv
// Top of the FSM state upset detector. Stores the FSM next state, checks
// it each cycle and returns either the state or the recovery code.
// Assumes RESET_STATE and RECOVERY_STATE are legal codes for MODE.
module guard_fsm_upset
    import guard_pkg::*;
#(
    parameter int unsigned        STATE_W        = 4,
    parameter enc_mode_e          MODE           = ENC_PARITY,
    parameter logic [STATE_W-1:0] RESET_STATE    = 4'b0001,
    parameter logic [STATE_W-1:0] RECOVERY_STATE = 4'b1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] next_state,
    input  logic [STATE_W+1:0] flip_mask,
    output logic [STATE_W-1:0] corrected_state,
    output logic               upset
);
    logic [STATE_W-1:0] state_q;
    logic [1:0]         par_q;
    logic               upset_raw;

    guard_store #(.STATE_W(STATE_W), .MODE(MODE), .RESET_STATE(RESET_STATE)) u_store (
        .clk(clk), .rst_n(rst_n), .next_state(next_state), .flip_mask(flip_mask),
        .state_q(state_q), .par_q(par_q)
    );

    guard_detect #(.STATE_W(STATE_W), .MODE(MODE)) u_detect (
        .state_q(state_q), .par_q(par_q), .upset_raw(upset_raw)
    );

    guard_recover #(.STATE_W(STATE_W), .RECOVERY_STATE(RECOVERY_STATE)) u_recover (
        .state_q(state_q), .upset_raw(upset_raw),
        .corrected_state(corrected_state), .upset(upset)
    );
endmodule

// File: rtl/guard_fsm_upset_chk.sv
// Assertion checker for guard_fsm_upset, attached by bind below.
module guard_fsm_upset_chk
    import guard_pkg::*;
#(
    parameter int unsigned        STATE_W        = 4,
    parameter enc_mode_e          MODE           = ENC_PARITY,
    parameter logic [STATE_W-1:0] RESET_STATE    = 4'b0001,
    parameter logic [STATE_W-1:0] RECOVERY_STATE = 4'b1000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STATE_W-1:0] next_state,
    input logic [STATE_W+1:0] flip_mask,
    input logic [STATE_W-1:0] corrected_state,
    input logic               upset
);
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!upset && corrected_state == RESET_STATE));

    a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !upset && $past(flip_mask) == '0)
        |-> corrected_state == $past(next_state));

    generate
        if (MODE == ENC_PARITY) begin : g_par
            a_r4_state_flip: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $countones($past(flip_mask[STATE_W-1:0])) == 1
                 && $past(flip_mask[STATE_W+1:STATE_W]) == 2'b00)
                |-> (upset && corrected_state == RECOVERY_STATE));
            a_r5_one_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(flip_mask[STATE_W-1:0]) == '0
                 && $countones($past(flip_mask[STATE_W+1:STATE_W])) == 1)
                |-> (!upset && corrected_state == $past(next_state)));
            a_r6_both_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(flip_mask[STATE_W-1:0]) == '0
                 && $past(flip_mask[STATE_W+1:STATE_W]) == 2'b11)
                |-> (upset && corrected_state == RECOVERY_STATE));
        end else if (MODE == ENC_ONE_HOT) begin : g_hot
            a_r8_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(corrected_state) == 1);
        end else begin : g_cold
            a_r9_onecold_out: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(~corrected_state) == 1);
        end
    endgenerate
endmodule

bind guard_fsm_upset guard_fsm_upset_chk #(
    .STATE_W(STATE_W), .MODE(MODE),
    .RESET_STATE(RESET_STATE), .RECOVERY_STATE(RECOVERY_STATE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .next_state(next_state), .flip_mask(flip_mask),
    .corrected_state(corrected_state), .upset(upset)
);

// File: tb/sim_guard_fsm_upset.sv
// Bench: three instances (parity, one-hot, one-cold) run a four-state
// rotating FSM through the block, with random and directed upsets.
module sim_guard_fsm_upset;
    import guard_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] nx [3];
    logic [5:0] fm [3];
    logic [3:0] co [3];
    logic       up [3];

    guard_fsm_upset #(.STATE_W(4), .MODE(ENC_PARITY),
        .RESET_STATE(4'b0001), .RECOVERY_STATE(4'b1000)) u0 (
        .clk(clk), .rst_n(rst_n), .next_state(nx[0]), .flip_mask(fm[0]),
        .corrected_state(co[0]), .upset(up[0]));
    guard_fsm_upset #(.STATE_W(4), .MODE(ENC_ONE_HOT),
        .RESET_STATE(4'b0001), .RECOVERY_STATE(4'b1000)) u1 (
        .clk(clk), .rst_n(rst_n), .next_state(nx[1]), .flip_mask(fm[1]),
        .corrected_state(co[1]), .upset(up[1]));
    guard_fsm_upset #(.STATE_W(4), .MODE(ENC_ONE_COLD),
        .RESET_STATE(4'b1110), .RECOVERY_STATE(4'b0111)) u2 (
        .clk(clk), .rst_n(rst_n), .next_state(nx[2]), .flip_mask(fm[2]),
        .corrected_state(co[2]), .upset(up[2]));

    localparam logic [3:0] REC [3] = '{4'b1000, 4'b1000, 4'b0111};
    localparam logic [3:0] RST [3] = '{4'b0001, 4'b0001, 4'b1110};

    int   n_checks = 0;
    int   n_errs   = 0;
    bit   done     = 1'b0;

    logic [3:0] mq [3];
    logic [1:0] mp [3];
    string      tg [3];
    logic [3:0] ovr_next [3];
    bit         ovr_use  [3];
    logic [5:0] msk      [3];

    // Expected upset for a stored state and parity, per mode.
    function automatic logic exp_up(input int m, input logic [3:0] q, input logic [1:0] p);
        case (m)
            0:       return (p[0] != ~^q) && (p[1] != ^q);
            1:       return $countones(q) != 1;
            default: return $countones(~q) != 1;
        endcase
    endfunction

    function automatic logic [3:0] exp_co(input int i);
        return exp_up(i, mq[i], mp[i]) ? REC[i] : mq[i];
    endfunction

    // Example FSM: rotate left on go, else hold (valid for hot and cold codes).
    function automatic logic [3:0] fsm_next(input logic [3:0] cur, input logic go);
        return go ? {cur[2:0], cur[3]} : cur;
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s %s got=%b exp=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, model the load, check at the next falling edge.
    task automatic tick(input bit r, input bit go);
        for (int i = 0; i < 3; i++) begin
            logic [3:0] n;
            logic       was_up;
            was_up = exp_up(i, mq[i], mp[i]);
            n = ovr_use[i] ? ovr_next[i] : fsm_next(exp_co(i), go);
            nx[i] = n;
            fm[i] = msk[i];
            if (r) begin
                mq[i] = RST[i];
                mp[i] = {^RST[i], ~^RST[i]};
            end else begin
                mq[i] = n ^ msk[i][3:0];
                mp[i] = {^n, ~^n} ^ msk[i][5:4];
            end
            if (r)                                            tg[i] = "R1";
            else if (i == 0 && msk[i][3:0] != 0)              tg[i] = "R4";
            else if (i == 0 && msk[i][5:4] == 2'b11)          tg[i] = "R6";
            else if (i == 0 && msk[i][5:4] != 0)              tg[i] = "R5";
            else if (i == 0 && ovr_use[i])                    tg[i] = "R3";
            else if (i == 1 && exp_up(i, mq[i], mp[i]))       tg[i] = "R8";
            else if (i == 2 && exp_up(i, mq[i], mp[i]))       tg[i] = "R9";
            else if (was_up)                                  tg[i] = "R7";
            else                                              tg[i] = "R2";
        end
        rst_n = !r;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(tg[i], {3'b000, up[i]}, {3'b000, exp_up(i, mq[i], mp[i])}, "upset");
            chk(tg[i], co[i], exp_co(i), "corrected_state");
            ovr_use[i] = 1'b0;
            msk[i]     = '0;
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            nx[i] = '0; fm[i] = '0; msk[i] = '0; ovr_use[i] = 1'b0;
            ovr_next[i] = '0; mq[i] = RST[i]; mp[i] = {^RST[i], ~^RST[i]};
        end
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: reset wins over an injected flip.
        msk[0] = 6'b110101; msk[1] = 6'b000011; msk[2] = 6'b000100;
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        // R4: flip bit 2 of 0001 to reach 0101 in the parity instance; R7 next.
        ovr_use[0] = 1'b1; ovr_next[0] = 4'b0001; msk[0] = 6'b000100;
        // R8: illegal 0101 driven straight into the one-hot instance.
        ovr_use[1] = 1'b1; ovr_next[1] = 4'b0101;
        // R9: two zeros in the one-cold instance.
        ovr_use[2] = 1'b1; ovr_next[2] = 4'b0101;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        // R8: all-zero code; R5: flip p0 only.
        ovr_use[1] = 1'b1; ovr_next[1] = 4'b0000; msk[0] = 6'b010000;
        tick(1'b0, 1'b1);
        // R5: flip p1 only; R8: parity flip bits ignored in one-hot mode.
        msk[0] = 6'b100000; msk[1] = 6'b110000;
        tick(1'b0, 1'b1);
        // R6: flip both parity flops.
        msk[0] = 6'b110000;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        // R3: codes outside the FSM's set pass through when parity matches.
        ovr_use[0] = 1'b1; ovr_next[0] = 4'b0110; tick(1'b0, 1'b0);
        ovr_use[0] = 1'b1; ovr_next[0] = 4'b1111; tick(1'b0, 1'b0);
        ovr_use[0] = 1'b1; ovr_next[0] = 4'b0000; tick(1'b0, 1'b0);
        ovr_use[0] = 1'b1; ovr_next[0] = 4'b0100; tick(1'b0, 1'b1);
        // Random mix of clean cycles and single upsets.
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom % 8);
            if (sel == 5)      msk[0] = 6'(1 << ($urandom % 4));
            else if (sel == 6) msk[0] = 6'(1 << (4 + $urandom % 2));
            else if (sel == 7) msk[0] = 6'b110000;
            if ($urandom % 6 == 0) msk[1] = 6'(1 << ($urandom % 6));
            if ($urandom % 6 == 0) msk[2] = 6'(1 << ($urandom % 4));
            tick($urandom % 50 == 0, 1'($urandom % 2));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end
endmodule